// File: doc/BRIEF.md
# Vectored Interrupt Router

This block gathers 64 interrupt inputs. It captures each one as either an edge event or a level, and tracks three 64-bit state words: pending, mask and in-service. A serviced source raises one of 64 output lines. The line is chosen by that source's entry in a byte-wide vector table. A later deassert evaluation for the same source drops the line again. Software reaches the block over a small 32-bit register bus. Each 64-bit register appears as a low word and a high word. The vector table and a companion route table are reached one byte per access.

Every evaluation serves one source only: the lowest-numbered eligible one. The block takes one step per clock cycle. An input change counts as a step, and so does an accepted bus write. When several inputs change together they are taken one per cycle, lowest index first. The bus is held off (`bus_ready` low) while any input change is still waiting, so input events always win over the bus.

Register word offsets (the bit-2 address selects the high word): identity 0x000, mask 0x020, edge select 0x028, clear 0x030, status 0x080, polarity 0x088. The vector table is at 0x400 + source and the route table at 0x800 + source. A byte access uses data bits [7:0].

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, mask reads all ones, edge select and status read zero, every vector byte reads 0, every route byte reads 1, `irq_out` is zero and `bus_ready` is high.
- R2: For a source whose edge-select bit is 0 (level), a rising input sets pending. If that source is unmasked, it goes in service and its line rises. A falling input clears pending and runs a deassert evaluation for that source.
- R3: For a source whose edge-select bit is 1, a rising input sets pending and runs an assert evaluation. A falling input runs a deassert evaluation but leaves pending set, so a later unmask serves the source again.
- R4: A mask word write keeps the other word. Bits going from 1 to 0 (masked to unmasked) get an assert evaluation: the lowest such bit that is pending goes in service. Bits going from 0 to 1 get a deassert evaluation.
- R5: A clear word write acts only if some written bit has edge select 1. It then clears pending for all written bits, drops the line of the lowest written in-service source, and clears in-service for all written bits.
- R6: A status word read returns in-service AND NOT mask. A status word write replaces that word of the in-service register and changes no line.
- R7: Vector entry bits [5:0] pick the output line. Vector and route bytes are stored and read back in data bits [7:0].
- R8: The edge-select and polarity words read back what was written. The identity low word reads 0x7A11C0DE and the high word reads 63.
- R9: Unmapped offsets read zero and ignore writes. This includes 0x040–0x04C and the write-only clear words.
- R10: While an input change is waiting, `bus_ready` is low and no bus access is accepted. Read data appears with `bus_rvalid` one cycle after the accepting edge.
- R11: Simultaneous input changes are processed one per cycle, lowest index first, so their lines rise on successive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Interrupt inputs, synchronous to clk |
| bus_valid | input | 1 | Bus request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Request accepted at this edge when high |
| bus_rdata | output | 32 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after acceptance |
| irq_out | output | 64 | Output interrupt lines |

## Verification
An input change that waits alone is applied at the next rising edge, so `irq_out` and status show it one cycle later. With k simultaneous changes, the last result is due after k cycles. A bus write takes effect at the edge that accepts it. Read data follows one edge after acceptance. The bench changes inputs and requests only just after a falling edge. It samples `bus_ready` before committing a request and compares `irq_out` at the following falling edge. Read expectations go into a queue that a monitor drains whenever `bus_rvalid` is seen, so a stalled read is still matched to its own expected value.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: shared address map, step encoding and decode helper for
// the vectored interrupt router. Assumes 12-bit byte addresses, word
// registers on 8-byte pairs (bit 2 selects the upper word).
package irqc_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_ID     = 12'h000;
    localparam logic [ADDR_W-1:0] A_MASK   = 12'h020;
    localparam logic [ADDR_W-1:0] A_EDGE   = 12'h028;
    localparam logic [ADDR_W-1:0] A_CLR    = 12'h030;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h080;
    localparam logic [ADDR_W-1:0] A_POL    = 12'h088;
    localparam logic [ADDR_W-1:0] A_VEC    = 12'h400;
    localparam logic [ADDR_W-1:0] A_RTE    = 12'h800;

    // Kind of state step taken in one cycle
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_RISE,
        OP_FALL,
        OP_MASK,
        OP_CLEAR
    } op_e;

    // True when addr falls on either word of the register pair at base
    function automatic logic pair_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base);
        return (addr[ADDR_W-1:3] == base[ADDR_W-1:3]) && (addr[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/irqc_lowest.sv
// Module irqc_lowest: finds the lowest set bit of a request vector.
// Purely combinational; idx is zero when nothing is requested.
module irqc_lowest #(
    parameter int N = 64
) (
    input  logic [N-1:0]         req,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    // Scan from the top so the lowest set bit is written last
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/irqc_byte_table.sv
// Module irqc_byte_table: N entries of W bits, written one entry per cycle,
// all entries visible in parallel. Assumes a single writer.
module irqc_byte_table #(
    parameter int            N         = 64,
    parameter int            W         = 8,
    parameter logic [W-1:0]  RESET_VAL = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(N)-1:0]   wr_idx,
    input  logic [W-1:0]           wr_data,
    output logic [N-1:0][W-1:0]    entries
);
    localparam int IW = $clog2(N);

    logic [N-1:0] ent_we;

    // Per-entry write enable decode
    for (genvar g = 0; g < N; g++) begin : g_we
        assign ent_we[g] = wr_en && (wr_idx == IW'(g));
    end

    // Entry storage with reset value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) entries[i] <= RESET_VAL;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ent_we[i]) entries[i] <= wr_data;
            end
        end
    end

    // R1: table holds the reset value after reset
    assert_table_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (entries[0] == RESET_VAL && entries[N-1] == RESET_VAL));
endmodule

// File: rtl/irq_route_ctrl.sv
// Module irq_route_ctrl: 2*DATA_W interrupt sources with per-source edge or
// level capture, pending / mask / in-service state, and routing of each
// serviced source to one of NOUT lines through a vector table.
// Assumes irq_in is synchronous to clk. One step per cycle: an input change
// (lowest index first) or an accepted bus access; input changes stall the bus.
module irq_route_ctrl
    import irqc_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                NOUT     = 64,
    parameter int                ENTRY_W  = 8,
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h7A11_C0DE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   irq_in,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic                  bus_ready,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_rvalid,
    output logic [NOUT-1:0]       irq_out
);
    localparam int NSRC   = 2 * DATA_W;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int LINE_W = $clog2(NOUT);

    logic [NSRC-1:0] mask_q, edge_q, pend_q, isr_q, last_q, pol_q;
    logic [NSRC-1:0] mask_n, edge_n, pend_n, isr_n, last_n, pol_n;
    logic [NOUT-1:0] out_n;
    logic [NSRC-1:0][ENTRY_W-1:0] vec_tab, rte_tab;

    // ---------------- input change detection ----------------
    logic [NSRC-1:0]  diff, ev_bit;
    logic             ev_found;
    logic [IDX_W-1:0] ev_idx;

    assign diff = irq_in ^ last_q;

    irqc_lowest #(.N(NSRC)) u_ev_pick (
        .req   (diff),
        .found (ev_found),
        .idx   (ev_idx)
    );

    assign ev_bit    = ev_found ? (NSRC'(1) << ev_idx) : '0;
    assign bus_ready = !ev_found;

    // ---------------- bus decode ----------------
    logic            acc_wr, acc_rd, hi_half;
    logic            wr_mask, wr_edge, wr_clr, wr_stat, wr_pol, clr_hit;
    logic            vec_hit, rte_hit;
    logic [NSRC-1:0] wide_data, keep_other, mask_wr_val;
    logic [IDX_W-1:0] tab_idx;

    assign acc_wr  = bus_valid && bus_ready && bus_write;
    assign acc_rd  = bus_valid && bus_ready && !bus_write;
    assign hi_half = bus_addr[2];
    assign tab_idx = bus_addr[IDX_W-1:0];
    assign vec_hit = bus_addr[ADDR_W-1:IDX_W] == A_VEC[ADDR_W-1:IDX_W];
    assign rte_hit = bus_addr[ADDR_W-1:IDX_W] == A_RTE[ADDR_W-1:IDX_W];

    assign wide_data  = hi_half ? {bus_wdata, {DATA_W{1'b0}}}
                                : {{DATA_W{1'b0}}, bus_wdata};
    assign keep_other = hi_half ? {{DATA_W{1'b0}}, {DATA_W{1'b1}}}
                                : {{DATA_W{1'b1}}, {DATA_W{1'b0}}};

    assign wr_mask = acc_wr && pair_hit(bus_addr, A_MASK);
    assign wr_edge = acc_wr && pair_hit(bus_addr, A_EDGE);
    assign wr_clr  = acc_wr && pair_hit(bus_addr, A_CLR);
    assign wr_stat = acc_wr && pair_hit(bus_addr, A_STAT);
    assign wr_pol  = acc_wr && pair_hit(bus_addr, A_POL);
    assign clr_hit = wr_clr && |(edge_q & wide_data);

    assign mask_wr_val = (mask_q & keep_other) | wide_data;

    // ---------------- step selection ----------------
    op_e op;

    // Choose the single state step for this cycle; inputs first
    always_comb begin
        if (ev_found)     op = irq_in[ev_idx] ? OP_RISE : OP_FALL;
        else if (wr_mask) op = OP_MASK;
        else if (clr_hit) op = OP_CLEAR;
        else              op = OP_IDLE;
    end

    // ---------------- assert / deassert candidates ----------------
    logic [NSRC-1:0]  a_cand, d_cand, a_oh, d_oh;
    logic             a_found, d_found;
    logic [IDX_W-1:0] a_idx, d_idx;
    logic [NOUT-1:0]  a_line_oh, d_line_oh;

    // Candidate sets for the assert and deassert evaluations
    always_comb begin
        a_cand = '0;
        d_cand = '0;
        case (op)
            OP_RISE:  a_cand = ev_bit & ~mask_q;
            OP_FALL:  d_cand = ev_bit & isr_q;
            OP_MASK: begin
                a_cand = mask_q & ~mask_wr_val & pend_q;
                d_cand = ~mask_q & mask_wr_val & isr_q;
            end
            OP_CLEAR: d_cand = wide_data & isr_q;
            default: ;
        endcase
    end

    irqc_lowest #(.N(NSRC)) u_as_pick (.req(a_cand), .found(a_found), .idx(a_idx));
    irqc_lowest #(.N(NSRC)) u_ds_pick (.req(d_cand), .found(d_found), .idx(d_idx));

    assign a_oh      = a_found ? (NSRC'(1) << a_idx) : '0;
    assign d_oh      = d_found ? (NSRC'(1) << d_idx) : '0;
    assign a_line_oh = a_found ? (NOUT'(1) << vec_tab[a_idx][LINE_W-1:0]) : '0;
    assign d_line_oh = d_found ? (NOUT'(1) << vec_tab[d_idx][LINE_W-1:0]) : '0;

    // ---------------- next state ----------------
    // Apply the chosen step and any plain register write
    always_comb begin
        mask_n = mask_q;
        edge_n = edge_q;
        pend_n = pend_q;
        last_n = last_q;
        pol_n  = pol_q;
        isr_n  = isr_q;
        case (op)
            OP_RISE: begin
                pend_n = pend_q | ev_bit;
                last_n = last_q | ev_bit;
            end
            OP_FALL: begin
                last_n = last_q & ~ev_bit;
                if ((edge_q & ev_bit) == '0) pend_n = pend_q & ~ev_bit;
            end
            OP_MASK:  mask_n = mask_wr_val;
            OP_CLEAR: begin
                pend_n = pend_q & ~wide_data;
                isr_n  = isr_q & ~wide_data;
            end
            default: ;
        endcase
        if (wr_edge) edge_n = (edge_q & keep_other) | wide_data;
        if (wr_pol)  pol_n  = (pol_q & keep_other) | wide_data;
        if (wr_stat) isr_n  = (isr_q & keep_other) | wide_data;
        isr_n = (isr_n | a_oh) & ~d_oh;
        out_n = (irq_out | a_line_oh) & ~d_line_oh;
    end

    // ---------------- tables ----------------
    irqc_byte_table #(.N(NSRC), .W(ENTRY_W), .RESET_VAL(ENTRY_W'(0))) u_vec_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr && vec_hit),
        .wr_idx  (tab_idx),
        .wr_data (bus_wdata[ENTRY_W-1:0]),
        .entries (vec_tab)
    );

    irqc_byte_table #(.N(NSRC), .W(ENTRY_W), .RESET_VAL(ENTRY_W'(1))) u_rte_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (acc_wr && rte_hit),
        .wr_idx  (tab_idx),
        .wr_data (bus_wdata[ENTRY_W-1:0]),
        .entries (rte_tab)
    );

    // ---------------- read mux ----------------
    logic [DATA_W-1:0] rd_word;
    logic [NSRC-1:0]   stat_view;

    assign stat_view = isr_q & ~mask_q;

    // Select one word for the read response
    always_comb begin
        rd_word = '0;
        if (vec_hit)                      rd_word = DATA_W'(vec_tab[tab_idx]);
        else if (rte_hit)                 rd_word = DATA_W'(rte_tab[tab_idx]);
        else if (pair_hit(bus_addr, A_ID))   rd_word = hi_half ? DATA_W'(NSRC - 1) : ID_VALUE;
        else if (pair_hit(bus_addr, A_MASK)) rd_word = hi_half ? mask_q[NSRC-1:DATA_W] : mask_q[DATA_W-1:0];
        else if (pair_hit(bus_addr, A_EDGE)) rd_word = hi_half ? edge_q[NSRC-1:DATA_W] : edge_q[DATA_W-1:0];
        else if (pair_hit(bus_addr, A_STAT)) rd_word = hi_half ? stat_view[NSRC-1:DATA_W] : stat_view[DATA_W-1:0];
        else if (pair_hit(bus_addr, A_POL))  rd_word = hi_half ? pol_q[NSRC-1:DATA_W] : pol_q[DATA_W-1:0];
    end

    // ---------------- registers ----------------
    // State, output lines and read response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '1;
            edge_q     <= '0;
            pend_q     <= '0;
            isr_q      <= '0;
            last_q     <= '0;
            pol_q      <= '0;
            irq_out    <= '0;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            mask_q     <= mask_n;
            edge_q     <= edge_n;
            pend_q     <= pend_n;
            isr_q      <= isr_n;
            last_q     <= last_n;
            pol_q      <= pol_n;
            irq_out    <= out_n;
            bus_rvalid <= acc_rd;
            if (acc_rd) bus_rdata <= rd_word;
        end
    end

    // ---------------- assertions ----------------
    // R1: reset leaves lines low, nothing in service, everything masked
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0 && isr_q == '0 && mask_q == '1 && !bus_rvalid));

    // R11: at most one source enters service per cycle (status writes aside)
    assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stat) |-> ($countones(isr_q & ~$past(isr_q)) <= 1));

    // R4: a source entering service is unmasked
    assert_grant_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_stat) |-> ((isr_q & ~$past(isr_q) & mask_q) == '0));

    // R5: a clear naming no edge source leaves pending untouched
    assert_clear_edge_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_clr && !clr_hit) |-> (pend_q == $past(pend_q)));

    // R7: a grant with no competing deassert raises the routed line
    assert_line_raised_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(a_found && !d_found) |-> |(irq_out & $past(a_line_oh)));

    // R10: a stalled request produces no read response
    assert_stall_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=> !bus_rvalid);
endmodule

// File: tb/tb_irq_route_ctrl.sv
// Bench for irq_route_ctrl: scoreboard of expected read words drained by a
// monitor on bus_rvalid, plus direct line checks one cycle after each step.
module tb_irq_route_ctrl;
    localparam int NS = 64;
    localparam int NO = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NO-1:0] irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t rd_q[$];

    always #10 clk = ~clk;

    irq_route_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    task automatic note(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pop one expected word per read response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (rd_q.size() == 0) begin
                note(1'b0, "R10 unexpected read response", 64'(bus_rdata), 64'h0);
            end else begin
                exp_t e;
                e = rd_q.pop_front();
                note(bus_rdata === e.exp, e.tag, 64'(bus_rdata), 64'(e.exp));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Hold the request until bus_ready was high across an edge
    task automatic wait_accept;
        bit acc;
        do begin
            #1;
            acc = bus_ready;
            @(negedge clk);
        end while (!acc);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        wait_accept();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        rd_q.push_back(e);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        wait_accept();
        bus_valid = 1'b0;
    endtask

    task automatic chk_out(input logic [63:0] exp, input string tag);
        #1;
        note(irq_out === exp, tag, irq_out, exp);
    endtask

    task automatic chk_ready(input bit exp, input string tag);
        #1;
        note(bus_ready === exp, tag, 64'(bus_ready), 64'(exp));
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk_out(64'h0, "R1 lines after reset");
        chk_ready(1'b1, "R1 ready after reset");
        bus_rd(12'h020, 32'hFFFF_FFFF, "R1 mask lo reset");
        bus_rd(12'h024, 32'hFFFF_FFFF, "R1 mask hi reset");
        bus_rd(12'h028, 32'h0, "R1 edge lo reset");
        bus_rd(12'h080, 32'h0, "R1 status lo reset");
        bus_rd(12'h405, 32'h0, "R1 vector reset");
        bus_rd(12'h805, 32'h1, "R1 route reset");
        bus_rd(12'h000, 32'h7A11_C0DE, "R8 id lo");
        bus_rd(12'h004, 32'd63, "R8 id hi");

        // R7 vector setup and readback
        bus_wr(12'h403, 32'hC5);
        bus_wr(12'h404, 32'h07);
        bus_wr(12'h40A, 32'h0A);
        bus_wr(12'h428, 32'h09);
        bus_wr(12'h429, 32'h0B);
        bus_wr(12'h414, 32'h14);
        bus_wr(12'h415, 32'h15);
        bus_rd(12'h403, 32'hC5, "R7 vector readback");
        bus_rd(12'h404, 32'h07, "R7 vector readback 2");

        // R2 level source 3 routed via 0xC5 -> line 5
        bus_wr(12'h020, 32'hFFFF_FFF7);
        irq_in[3] = 1'b1;
        tick(1);
        chk_out(64'h1 << 5, "R2 level rise raises line 5 (R7 low six bits)");
        bus_rd(12'h080, 32'h8, "R2 status lo after rise");
        irq_in[3] = 1'b0;
        tick(1);
        chk_out(64'h0, "R2 level fall drops line");
        bus_rd(12'h080, 32'h0, "R2 status lo after fall");

        // R4 unmask two pending: only lowest is served
        irq_in[4] = 1'b1;
        irq_in[10] = 1'b1;
        chk_ready(1'b0, "R10 ready low on input change");
        tick(2);
        chk_out(64'h0, "R4 masked sources stay quiet");
        bus_wr(12'h020, 32'hFFFF_FBE7);
        chk_out(64'h1 << 7, "R4 unmask serves lowest only");
        bus_rd(12'h080, 32'h10, "R4 status shows lowest only");
        bus_wr(12'h020, 32'hFFFF_FBF7);
        chk_out(64'h0, "R4 re-mask drops line");
        bus_rd(12'h080, 32'h0, "R4 status after re-mask");
        bus_wr(12'h024, 32'hFFFF_FEFF);
        bus_rd(12'h020, 32'hFFFF_FBF7, "R4 mask lo kept on hi write");
        bus_rd(12'h024, 32'hFFFF_FEFF, "R4 mask hi written");

        // R11 two falls processed one per cycle
        irq_in[4] = 1'b0;
        irq_in[10] = 1'b0;
        chk_ready(1'b0, "R11 ready low with two changes");
        tick(1);
        chk_ready(1'b0, "R11 one change left after one cycle");
        tick(1);
        chk_ready(1'b1, "R11 ready after two cycles");
        chk_out(64'h0, "R11 no lines after level falls");

        // R3 edge source 40 -> line 9
        bus_wr(12'h02C, 32'h100);
        bus_rd(12'h02C, 32'h100, "R8 edge hi readback");
        irq_in[40] = 1'b1;
        tick(1);
        chk_out(64'h1 << 9, "R3 edge rise raises line 9");
        bus_rd(12'h084, 32'h100, "R3 status hi after rise");
        irq_in[40] = 1'b0;
        tick(1);
        chk_out(64'h0, "R3 edge fall drops line");
        bus_rd(12'h084, 32'h0, "R3 status hi after fall");
        bus_wr(12'h024, 32'hFFFF_FFFF);
        chk_out(64'h0, "R3 mask with nothing in service");
        bus_wr(12'h024, 32'hFFFF_FEFF);
        chk_out(64'h1 << 9, "R3 pending kept, unmask serves again");

        // R5 clear behaviour
        irq_in[3] = 1'b1;
        tick(1);
        chk_out((64'h1 << 9) | (64'h1 << 5), "R5 setup two lines");
        bus_wr(12'h030, 32'h8);
        chk_out((64'h1 << 9) | (64'h1 << 5), "R5 clear of level-only bit ignored");
        bus_rd(12'h080, 32'h8, "R5 level in-service kept");
        bus_wr(12'h034, 32'h100);
        chk_out(64'h1 << 5, "R5 clear of edge bit drops its line");
        bus_rd(12'h084, 32'h0, "R5 status hi cleared");
        bus_wr(12'h024, 32'hFFFF_FFFF);
        bus_wr(12'h024, 32'hFFFF_FEFF);
        chk_out(64'h1 << 5, "R5 pending removed by clear");
        irq_in[3] = 1'b0;
        tick(1);
        chk_out(64'h0, "R2 level fall again");

        // R5 clear over two in-service edge sources drops lowest line only
        bus_wr(12'h02C, 32'h300);
        bus_wr(12'h024, 32'hFFFF_FCFF);
        irq_in[40] = 1'b1;
        irq_in[41] = 1'b1;
        tick(2);
        chk_out((64'h1 << 9) | (64'h1 << 11), "R3 two edge sources served");
        bus_wr(12'h034, 32'h300);
        chk_out(64'h1 << 11, "R5 clear drops only lowest line");
        bus_rd(12'h084, 32'h0, "R5 all written in-service cleared");
        irq_in[40] = 1'b0;
        irq_in[41] = 1'b0;
        tick(2);
        chk_out(64'h1 << 11, "R3 falls with nothing in service");

        // R6 status write
        bus_wr(12'h084, 32'h200);
        chk_out(64'h1 << 11, "R6 status write leaves lines");
        bus_rd(12'h084, 32'h200, "R6 status hi readback");
        bus_wr(12'h024, 32'hFFFF_FEFF);
        chk_out(64'h0, "R4 masking in-service source drops line");
        bus_wr(12'h080, 32'h18);
        bus_rd(12'h080, 32'h8, "R6 status hides masked bit");
        bus_wr(12'h080, 32'h0);
        bus_rd(12'h080, 32'h0, "R6 status lo cleared");

        // R8 polarity storage
        bus_wr(12'h08C, 32'hA5A5_0001);
        bus_rd(12'h08C, 32'hA5A5_0001, "R8 polarity hi readback");
        bus_rd(12'h088, 32'h0, "R8 polarity lo untouched");

        // R9 unmapped and reserved offsets
        bus_wr(12'h040, 32'hFFFF_FFFF);
        bus_rd(12'h040, 32'h0, "R9 reserved reads zero");
        bus_rd(12'h030, 32'h0, "R9 clear word reads zero");
        bus_rd(12'h3FC, 32'h0, "R9 unmapped reads zero");
        bus_rd(12'h020, 32'hFFFF_FBF7, "R9 reserved write ignored");
        chk_out(64'h0, "R9 lines unchanged");

        // R7 route table
        bus_wr(12'h807, 32'h33);
        bus_rd(12'h807, 32'h33, "R7 route readback");
        bus_rd(12'h806, 32'h1, "R7 neighbour route kept");

        // R11 simultaneous rises served lowest first
        bus_wr(12'h020, 32'hFFCF_FBF7);
        irq_in[20] = 1'b1;
        irq_in[21] = 1'b1;
        tick(1);
        chk_out(64'h1 << 20, "R11 lowest source first");
        tick(1);
        chk_out((64'h1 << 20) | (64'h1 << 21), "R11 second source next cycle");

        // R10 read stalled behind input changes
        irq_in[20] = 1'b0;
        irq_in[21] = 1'b0;
        bus_rd(12'h020, 32'hFFCF_FBF7, "R10 stalled read data");
        chk_out(64'h0, "R10 changes done before read accepted");

        tick(2);
        note(rd_q.size() == 0, "R10 all reads answered", 64'(rd_q.size()), 64'h0);
        report();
    end
endmodule